// File: doc/BRIEF.md
# Cascadable Bit-Serial Configuration Store

This block holds a configuration bitstream and hands it out one bit per rising edge of an external configuration clock. It is meant to sit in front of a programmable-logic device that loads itself as a clock master: the device drives the clock, samples the serial data line and keeps clocking until it is configured. An internal bit address counter selects the bit shown on the data line, and each enabled edge moves the counter on by one. The data line has a separate drive enable, which stands for a tri-state driver.

Several instances can be chained to hold a bitstream longer than one store. The first store's active-low chain output feeds the active-low chip-enable input of the next store. When the last bit of a store has been consumed, that store stops driving the data line and pulls its chain output low. The next store then takes over the shared line. A reset/output-enable input can return the counter to zero, and its active level is chosen by a separate polarity input. After an asynchronous reset, a power-on cycle of fixed length holds a ready indicator low. When the serial-enable input is low, the store is in loading mode and a word-wide write port fills its array.

Top module: `ser_cfg_store`

## Requirements
- R1: The store can read when its power-on cycle is over, `ceN` is 0, `serEn` is 1 and reset/OE is inactive. While it can read and has not finished, `dataEn` is 1 and `dataBit` shows stream bit k at address k. Stream bit k is bit (k mod WORD_W) of word (k / WORD_W), so word 0 comes first and each word goes out LSB first. Each rising edge in this state moves the address on by one.
- R2: The edge that consumes bit DEPTH-1 marks the store finished. From then on `dataEn` is 0, and `ceoN` is 0 whenever `ceN` is 0 and `serEn` is 1.
- R3: When `ceN` is 1 (standby), `dataEn` is 0 and `ceoN` is 1, whatever the reset/OE input is. The address does not change.
- R4: When reset/OE is active, a rising edge sets the address to zero and clears the finished state. While reset/OE is active, `dataEn` is 0.
- R5: Reset/OE is active when `rstOe` equals `rstPolHigh`: with `rstPolHigh`=1 it is active high, and with `rstPolHigh`=0 it is active low.
- R6: After `rstAsyncN` is released, `readyDrvLow` stays 1 for POR_CYCLES rising edges and is 0 from then on. While `readyDrvLow` is 1, `dataEn` is 0 and the address does not advance.
- R7: When `serEn` is 0, `dataEn` is 0 and `ceoN` is 1. A rising edge with `wrEn`=1 writes `wrData` into word `wrAddr`.
- R8: In a chain of two stores, where the second store's `ceN` is the first store's `ceoN`, the data line carries both contents back to back: first store, then second. At no time are both stores driving.
- R9: If reset/OE is active on the same edge that would consume bit DEPTH-1, the clear wins. The address goes to zero and `ceoN` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration clock; the rising edge advances the address |
| rstAsyncN | input | 1 | Asynchronous power-on reset, active low |
| ceN | input | 1 | Chip enable, active low; high selects standby |
| rstOe | input | 1 | Reset/output-enable; active level set by rstPolHigh |
| rstPolHigh | input | 1 | 1: rstOe active high; 0: rstOe active low |
| serEn | input | 1 | 1: serial read mode; 0: loading mode |
| wrEn | input | 1 | Word write strobe, used in loading mode |
| wrAddr | input | $clog2(WORDS) | Word address for a write |
| wrData | input | WORD_W | Word written into the array |
| dataBit | output | 1 | Serial data value, meaningful when dataEn is 1 |
| dataEn | output | 1 | Drive enable of the serial data line |
| ceoN | output | 1 | Chain output, active low, goes low once the store is finished |
| readyDrvLow | output | 1 | Open-drain pull-down of the ready line, 1 during the power-on cycle |

## Verification
Two functions can fall in the same cycle. One is a reset/OE clear. The other is the edge that consumes the final bit and would set the chain output low. The bench lets the store advance to address DEPTH-1 and asserts reset/OE for exactly the next edge. It then checks that the chain output stays high, that the next store never starts driving, and that the stream starts again from bit 0. A behavioural model of both chained stores is compared on every clock, so the model also checks the clear that arrives in the middle of a stream, standby and loading mode.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

  // Strobes from control to datapath, valid for the coming rising edge
  typedef struct packed {
    logic advance;  // consume the current bit and move the address on
    logic clear;    // reset/OE active: address back to zero
    logic write;    // loading mode word write
    logic drive;    // data line driver enabled
  } cfgStrobe_t;

endpackage

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
  import ser_cfg_pkg::*;
#(
  parameter int POR_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       rstOe,
  input  logic       rstPolHigh,
  input  logic       serEn,
  input  logic       wrEn,
  input  logic       lastBit,
  output cfgStrobe_t strobe,
  output logic       ceoN,
  output logic       readyDrvLow
);

  localparam int PorW = $clog2(POR_CYCLES + 1);
  localparam logic [PorW-1:0] PorLast = PorW'(POR_CYCLES);

  logic [PorW-1:0] porCnt;
  logic            porDone;
  logic            resetAct;
  logic            readOk;
  logic            done;

  // Power-on cycle counter, saturates at POR_CYCLES
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              porCnt <= '0;
    else if (porCnt != PorLast) porCnt <= porCnt + 1'b1;
  end

  assign porDone     = (porCnt == PorLast);
  assign readyDrvLow = ~porDone;

  assign resetAct = (rstOe == rstPolHigh);
  assign readOk   = porDone & ~ceN & serEn & ~resetAct;

  always_comb begin
    strobe         = '0;
    strobe.clear   = resetAct;
    strobe.drive   = readOk & ~done;
    strobe.advance = readOk & ~done;
    strobe.write   = ~serEn & wrEn;
  end

  // Finished flag: set on the edge consuming the final bit, clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               done <= 1'b0;
    else if (strobe.clear)                   done <= 1'b0;
    else if (strobe.advance && lastBit)      done <= 1'b1;
  end

  assign ceoN = ~(done & ~ceN & serEn);

  // R2
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && lastBit && !strobe.clear) |=> done);

  // R9
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !done);

  // R6
  ready_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readyDrvLow |=> !readyDrvLow);

endmodule

// File: rtl/ser_cfg_dp.sv
module ser_cfg_dp
  import ser_cfg_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int WORDS  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobe_t               strobe,
  input  logic [$clog2(WORDS)-1:0] wrAddr,
  input  logic [WORD_W-1:0]        wrData,
  output logic                     rawBit,
  output logic                     lastBit
);

  localparam int DEPTH  = WORDS * WORD_W;
  localparam int BitAw  = $clog2(DEPTH);
  localparam int WordAw = $clog2(WORDS);
  localparam int SelW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BitAw-1:0] AddrLast = BitAw'(DEPTH - 1);

  logic [WORD_W-1:0] mem [WORDS];
  logic [BitAw-1:0]  addr;
  logic [WordAw-1:0] wordSel;
  logic [SelW-1:0]   bitSel;

  always_ff @(posedge clk) begin
    if (strobe.write) mem[wrAddr] <= wrData;
  end

  // Bit address counter; clear takes priority over advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          addr <= '0;
    else if (strobe.clear)              addr <= '0;
    else if (strobe.advance && !lastBit) addr <= addr + 1'b1;
  end

  generate
    if (WORD_W > 1) begin : g_multi
      assign bitSel  = addr[SelW-1:0];
      assign wordSel = addr[BitAw-1 -: WordAw];
    end else begin : g_single
      assign bitSel  = 1'b0;
      assign wordSel = addr[WordAw-1:0];
    end
  endgenerate

  assign rawBit  = mem[wordSel][bitSel];
  assign lastBit = (addr == AddrLast);

  // R4
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (addr == '0));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear && !lastBit) |=> (addr == $past(addr) + 1'b1));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.clear) |=> $stable(addr));

endmodule

// File: rtl/ser_cfg_store.sv
module ser_cfg_store
  import ser_cfg_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int WORDS      = 16,
  parameter int POR_CYCLES = 6
) (
  input  logic                     cfgClk,
  input  logic                     rstAsyncN,
  input  logic                     ceN,
  input  logic                     rstOe,
  input  logic                     rstPolHigh,
  input  logic                     serEn,
  input  logic                     wrEn,
  input  logic [$clog2(WORDS)-1:0] wrAddr,
  input  logic [WORD_W-1:0]        wrData,
  output logic                     dataBit,
  output logic                     dataEn,
  output logic                     ceoN,
  output logic                     readyDrvLow
);

  cfgStrobe_t strobe;
  logic       lastBit;
  logic       rawBit;

  ser_cfg_ctrl #(.POR_CYCLES(POR_CYCLES)) u_ctrl (
    .clk        (cfgClk),
    .rstN       (rstAsyncN),
    .ceN        (ceN),
    .rstOe      (rstOe),
    .rstPolHigh (rstPolHigh),
    .serEn      (serEn),
    .wrEn       (wrEn),
    .lastBit    (lastBit),
    .strobe     (strobe),
    .ceoN       (ceoN),
    .readyDrvLow(readyDrvLow)
  );

  ser_cfg_dp #(.WORD_W(WORD_W), .WORDS(WORDS)) u_dp (
    .clk    (cfgClk),
    .rstN   (rstAsyncN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rawBit (rawBit),
    .lastBit(lastBit)
  );

  assign dataEn  = strobe.drive;
  assign dataBit = strobe.drive & rawBit;

  // R3, R7
  drive_mode_chk: assert property (@(posedge cfgClk) disable iff (!rstAsyncN)
    dataEn |-> (!ceN && serEn && !readyDrvLow));

  // R2
  ceo_excl_chk: assert property (@(posedge cfgClk) disable iff (!rstAsyncN)
    !ceoN |-> !dataEn);

endmodule

// File: tb/ser_cfg_store_bench.sv
module ser_cfg_store_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int N     = 16;
  localparam int POR   = 6;
  localparam int DEPTH = N * W;
  localparam int AW    = $clog2(N);

  logic clk = 1'b0;
  logic rstN, ceTop, rstOe, pol, serEn, wrEnA, wrEnB;
  logic [AW-1:0] wrAddr;
  logic [W-1:0]  wrData;
  logic dA, eA, ceoA, rdyA, dB, eB, ceoB, rdyB;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_cfg_store #(.WORD_W(W), .WORDS(N), .POR_CYCLES(POR)) u_ser_cfg_store (
    .cfgClk(clk), .rstAsyncN(rstN), .ceN(ceTop), .rstOe(rstOe), .rstPolHigh(pol),
    .serEn(serEn), .wrEn(wrEnA), .wrAddr(wrAddr), .wrData(wrData),
    .dataBit(dA), .dataEn(eA), .ceoN(ceoA), .readyDrvLow(rdyA));

  ser_cfg_store #(.WORD_W(W), .WORDS(N), .POR_CYCLES(POR)) u_ser_cfg_store_nxt (
    .cfgClk(clk), .rstAsyncN(rstN), .ceN(ceoA), .rstOe(rstOe), .rstPolHigh(pol),
    .serEn(serEn), .wrEn(wrEnB), .wrAddr(wrAddr), .wrData(wrData),
    .dataBit(dB), .dataEn(eB), .ceoN(ceoB), .readyDrvLow(rdyB));

  // ---------------- reference model ----------------
  logic [W-1:0] mA [N];
  logic [W-1:0] mB [N];
  int addrA, addrB, porCnt;
  bit doneA, doneB;
  logic stream [$];

  function automatic bit resetAct();
    return (rstOe == pol);
  endfunction

  function automatic bit readOk(bit ce);
    return (porCnt == POR) && !ce && serEn && !resetAct();
  endfunction

  function automatic bit expCeo(bit d, bit ce);
    return !(d && !ce && serEn);
  endfunction

  task automatic stepDev(ref int a, ref bit d, input bit ce);
    if (resetAct()) begin
      a = 0; d = 0;
    end else if (readOk(ce) && !d) begin
      if (a == DEPTH-1) d = 1;
      else a = a + 1;
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrA = 0; addrB = 0; doneA = 0; doneB = 0; porCnt = 0;
    end else begin
      bit ceB;
      ceB = expCeo(doneA, ceTop);
      stepDev(addrA, doneA, ceTop);
      stepDev(addrB, doneB, ceB);
      if (!serEn && wrEnA) mA[wrAddr] = wrData;
      if (!serEn && wrEnB) mB[wrAddr] = wrData;
      if (porCnt < POR) porCnt++;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tagNow();
    if (!serEn)            return "R7";
    if (ceTop)             return "R3";
    if (resetAct() && pol) return "R5";
    if (resetAct())        return "R4";
    if (porCnt != POR)     return "R6";
    return "R1";
  endfunction

  // Compare on every falling edge
  always @(negedge clk) begin
    bit ceB, enA, enB;
    string t;
    t   = tagNow();
    ceB = expCeo(doneA, ceTop);
    enA = readOk(ceTop) && !doneA;
    enB = readOk(ceB) && !doneB;
    chk(rdyA == (porCnt != POR), "R6", "ready A", rdyA, porCnt != POR);
    chk(eA == enA, t, "drive A", eA, enA);
    chk(eB == enB, t, "drive B", eB, enB);
    chk(ceoA == ceB, "R2", "ceo A", ceoA, ceB);
    chk(ceoB == expCeo(doneB, ceB), "R2", "ceo B", ceoB, expCeo(doneB, ceB));
    chk(!(eA && eB), "R8", "contention", eA && eB, 0);
    if (enA) chk(dA == mA[addrA / W][addrA % W], t, "bit A", dA, mA[addrA / W][addrA % W]);
    if (enB) chk(dB == mB[addrB / W][addrB % W], t, "bit B", dB, mB[addrB / W][addrB % W]);
    if (eA) stream.push_back(dA);
    else if (eB) stream.push_back(dB);
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 0; ceTop = 0; rstOe = 1; pol = 0; serEn = 0;
    wrEnA = 0; wrEnB = 0; wrAddr = '0; wrData = '0;
    cyc(2);
    @(negedge clk);
    chk(rdyA == 1 && eA == 0 && ceoA == 1, "R6", "reset state", {rdyA, eA, ceoA}, 3'b101);
    @(posedge clk); #1;
    rstN = 1;

    // R7 loading both stores
    for (int i = 0; i < N; i++) begin
      wrAddr = AW'(i); wrData = W'((i * 37) ^ 8'hA5); wrEnA = 1; cyc(1);
    end
    wrEnA = 0;
    for (int i = 0; i < N; i++) begin
      wrAddr = AW'(i); wrData = W'((i * 91) ^ 8'h3C); wrEnB = 1; cyc(1);
    end
    wrEnB = 0;

    // R8 full chained stream
    stream.delete();
    serEn = 1;
    cyc(2 * DEPTH + 4);
    begin
      bit ok;
      ok = (stream.size() == 2 * DEPTH);
      chk(ok, "R8", "stream length", stream.size(), 2 * DEPTH);
      if (ok) for (int k = 0; k < 2 * DEPTH; k++) begin
        logic e;
        e = (k < DEPTH) ? mA[k / W][k % W] : mB[(k - DEPTH) / W][(k - DEPTH) % W];
        if (stream[k] !== e) chk(0, "R8", "stream bit", stream[k], e);
      end
    end
    @(negedge clk);
    chk(ceoB == 0, "R2", "chain end ceo", ceoB, 0);
    @(posedge clk); #1;

    // R4 reset pulse restarts both; standby; loading mid-stream
    rstOe = 0; cyc(1); rstOe = 1;
    cyc(DEPTH / 2);
    ceTop = 1; rstOe = 0; cyc(3); rstOe = 1; cyc(3); ceTop = 0;
    cyc(DEPTH);
    serEn = 0; wrAddr = AW'(2); wrData = 8'h0F; wrEnB = 1; cyc(1); wrEnB = 0; cyc(3);
    serEn = 1;
    cyc(DEPTH + 20);

    // R5 polarity high
    pol = 1; rstOe = 0; cyc(5);
    rstOe = 1; cyc(1); rstOe = 0; cyc(40);

    // R9 clear on the final-bit edge
    rstOe = 1; cyc(1); rstOe = 0;
    cyc(DEPTH - 1);
    rstOe = 1; cyc(1);
    @(negedge clk);
    chk(ceoA == 1, "R9", "ceo after clash", ceoA, 1);
    chk(eB == 0, "R9", "next store idle", eB, 0);
    @(posedge clk); #1;
    rstOe = 0; cyc(30);

    // R6 asynchronous reset mid-stream
    rstN = 0; cyc(1); rstN = 1;
    cyc(POR + 20);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule